// File: doc/BRIEF.md
# Tail-Biting Rate-1/3 Convolutional Encoder

This block turns a complete information frame into a rate-1/3 convolutionally coded stream using a code with constraint length 7 and six memory cells. Because it runs in tail-biting mode, the encoder never starts from an all-zero state and never appends flush bits. Instead, its shift register is loaded with the frame's final six bits before the first bit is coded. The trellis path therefore starts and ends in the same state, and the coded length is exactly three times the frame length.

A frame opens with a one-cycle `start` pulse that carries the frame length. Information bits then arrive one per accepted valid/ready handshake. The whole frame is stored while it arrives, because the preload depends on its last bits. At the same time, a shadow copy of the shift register tracks the newest six bits, so the preload is already in place when the final bit lands. Coding then emits one three-bit code word per cycle. A final flag marks the last word, and a done pulse follows it.

Top module: `tailbite_conv_enc`

## Requirements
- R1: A `start` pulse in the idle state with `frame_len` L, where 6 <= L <= MAX_LEN, opens a frame. `in_ready` is then high until exactly L bits have been accepted, a bit being accepted on a clock edge where both `in_valid` and `in_ready` are high.
- R2: After the last information bit is accepted, exactly L code words appear with `out_valid` high on L consecutive cycles.
- R3: For input bit u, the window is w = {u, r0, r1, r2, r3, r4, r5}, with u as the most significant bit and r0 the most recently shifted register bit. The outputs are `out_code[0]` = XOR of (w AND octal 133), `out_code[1]` = XOR of (w AND octal 171), and `out_code[2]` = XOR of (w AND octal 165).
- R4: Before the first bit is coded, r0..r5 hold bits L-1 down to L-6 of the frame, where bit 0 is the first bit received. No termination bits are added.
- R5: `out_last` is high together with the final code word of a frame and at no other time.
- R6: `done` is high for exactly one cycle, in the cycle right after the final code word.
- R7: A `start` in the idle state with L < 6 or L > MAX_LEN is rejected. `err` pulses high in the next cycle, no bit is accepted and no code word is produced.
- R8: A `start` while bits are being collected or coded is ignored. The running frame keeps its length and its output, and `err` stays low.
- R9: `in_ready` is low whenever the block is not collecting bits, and `in_bit` has no effect on a cycle where `in_valid` is low.
- R10: After reset, `in_ready`, `out_valid`, `out_last`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Frame-open pulse; `frame_len` is sampled with it |
| frame_len | input | LEN_W | Frame length in bits |
| in_valid | input | 1 | `in_bit` carries an information bit |
| in_bit | input | 1 | Information bit, in frame order |
| in_ready | output | 1 | Block is collecting frame bits |
| out_valid | output | 1 | `out_code` holds a code word |
| out_code | output | 3 | Code word; bit k is parity stream k |
| out_last | output | 1 | Final code word of the frame |
| done | output | 1 | One-cycle pulse after the final code word |
| err | output | 1 | One-cycle pulse on a rejected frame length |

## Verification
The behaviour hardest to reach from the ports is the preload. Its effect shows only in the first six code words, and it disappears whenever the last six bits are zero. The stimulus therefore includes an all-ones frame of exactly six bits, where every code word must be 3'b111, and random frames whose tails are random. Ignored starts are driven in the middle of bit collection and again during coding, with lengths that would visibly change the frame or raise `err`. This checks that a busy block keeps its frame intact.

// File: rtl/tbenc_pkg.sv
package tbenc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_CODE = 2'd2
  } enc_state_e;

  localparam int unsigned CODE_K      = 7;
  localparam int unsigned CODE_OUTS   = 3;
  localparam logic [CODE_OUTS*CODE_K-1:0] CODE_GENS = {7'o165, 7'o171, 7'o133};

endpackage

// File: rtl/tbenc_frame_store.sv
module tbenc_frame_store #(
  parameter int unsigned MAX_LEN = 384,
  parameter int unsigned IDX_W   = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);

  logic [MAX_LEN-1:0] mem_q;
  logic [MAX_LEN-1:0] mem_d;

  always_comb begin
    mem_d = mem_q;
    if (wr_en) begin
      mem_d[wr_idx] = wr_bit;
    end
  end

  always_ff @(posedge clk) begin
    mem_q <= mem_d;
  end

  assign rd_bit = mem_q[rd_idx];

endmodule

// File: rtl/tbenc_conv_core.sv
module tbenc_conv_core #(
  parameter int unsigned CONSTR_LEN = 7,
  parameter int unsigned NUM_OUT    = 3,
  parameter logic [NUM_OUT*CONSTR_LEN-1:0] GENS = {7'o165, 7'o171, 7'o133}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               shift_bit,
  input  logic               emit_en,
  output logic [NUM_OUT-1:0] code_o
);

  localparam int unsigned MEM_W = CONSTR_LEN - 1;

  logic [MEM_W-1:0]      reg_q;
  logic [MEM_W-1:0]      reg_d;
  logic [CONSTR_LEN-1:0] win;
  logic [NUM_OUT-1:0]    par;
  logic [NUM_OUT-1:0]    code_q;
  logic [NUM_OUT-1:0]    code_d;

  // window: newest bit on top, register bits below in order of age
  assign win[MEM_W] = shift_bit;
  for (genvar j = 0; j < MEM_W; j++) begin : g_win
    assign win[MEM_W-1-j] = reg_q[j];
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_par
    assign par[k] = ^(GENS[k*CONSTR_LEN +: CONSTR_LEN] & win);
  end

  always_comb begin
    reg_d  = reg_q;
    code_d = code_q;
    if (shift_en) begin
      reg_d = {reg_q[MEM_W-2:0], shift_bit};
    end
    if (emit_en) begin
      code_d = par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      code_q <= '0;
    end else begin
      reg_q  <= reg_d;
      code_q <= code_d;
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/tbenc_ctrl.sv
module tbenc_ctrl
  import tbenc_pkg::*;
#(
  parameter int unsigned MAX_LEN = 384,
  parameter int unsigned MIN_LEN = 6,
  parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1),
  parameter int unsigned IDX_W   = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] idx,
  output logic             shift_en,
  output logic             code_phase,
  output logic             out_valid,
  output logic             out_last,
  output logic             done,
  output logic             err,
  output enc_state_e       st
);

  enc_state_e       st_q, st_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             ov_q, ov_d;
  logic             ol_q, ol_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic [IDX_W-1:0] last_idx;
  logic             len_bad;

  assign last_idx = IDX_W'(len_q - LEN_W'(1));
  assign len_bad  = (frame_len < LEN_W'(MIN_LEN)) || (frame_len > LEN_W'(MAX_LEN));

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    ov_d     = 1'b0;
    ol_d     = 1'b0;
    err_d    = 1'b0;
    done_d   = ov_q & ol_q;
    wr_en    = 1'b0;
    shift_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (len_bad) begin
            err_d = 1'b1;
          end else begin
            st_d  = ST_FILL;
            len_d = frame_len;
            cnt_d = '0;
          end
        end
      end
      ST_FILL: begin
        if (in_valid) begin
          wr_en    = 1'b1;
          shift_en = 1'b1;
          if (cnt_q == last_idx) begin
            st_d  = ST_CODE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + IDX_W'(1);
          end
        end
      end
      ST_CODE: begin
        shift_en = 1'b1;
        ov_d     = 1'b1;
        ol_d     = (cnt_q == last_idx);
        if (cnt_q == last_idx) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + IDX_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      len_q  <= '0;
      ov_q   <= 1'b0;
      ol_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      ov_q   <= ov_d;
      ol_q   <= ol_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign in_ready   = (st_q == ST_FILL);
  assign code_phase = (st_q == ST_CODE);
  assign idx        = cnt_q;
  assign out_valid  = ov_q;
  assign out_last   = ol_q;
  assign done       = done_q;
  assign err        = err_q;
  assign st         = st_q;

endmodule

// File: rtl/tailbite_conv_enc.sv
module tailbite_conv_enc
  import tbenc_pkg::*;
#(
  parameter int unsigned MAX_LEN = 384,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
  localparam int unsigned IDX_W  = $clog2(MAX_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LEN_W-1:0]     frame_len,
  input  logic                 in_valid,
  input  logic                 in_bit,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [CODE_OUTS-1:0] out_code,
  output logic                 out_last,
  output logic                 done,
  output logic                 err
);

  localparam int unsigned MIN_LEN = CODE_K - 1;

  logic [1:0]       sync_q;
  logic             rst_sync_n;
  logic             wr_en;
  logic [IDX_W-1:0] idx;
  logic             shift_en;
  logic             code_phase;
  logic             rd_bit;
  logic             shift_bit;
  enc_state_e       st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = sync_q[1];

  tbenc_ctrl #(
    .MAX_LEN (MAX_LEN),
    .MIN_LEN (MIN_LEN),
    .LEN_W   (LEN_W),
    .IDX_W   (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .frame_len  (frame_len),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .wr_en      (wr_en),
    .idx        (idx),
    .shift_en   (shift_en),
    .code_phase (code_phase),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .done       (done),
    .err        (err),
    .st         (st)
  );

  tbenc_frame_store #(
    .MAX_LEN (MAX_LEN),
    .IDX_W   (IDX_W)
  ) u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_idx (idx),
    .wr_bit (in_bit),
    .rd_idx (idx),
    .rd_bit (rd_bit)
  );

  assign shift_bit = code_phase ? rd_bit : in_bit;

  tbenc_conv_core #(
    .CONSTR_LEN (CODE_K),
    .NUM_OUT    (CODE_OUTS),
    .GENS       (CODE_GENS)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .shift_en  (shift_en),
    .shift_bit (shift_bit),
    .emit_en   (code_phase),
    .code_o    (out_code)
  );

endmodule

// File: rtl/tbenc_checker.sv
module tbenc_checker
  import tbenc_pkg::*;
#(
  parameter int unsigned MIN_LEN = 6,
  parameter int unsigned LEN_W   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] frame_len,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_last,
  input logic             done,
  input logic             err,
  input enc_state_e       st
);

  // R9: collection and coded output never overlap
  p_fill_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  // R2: code words come back to back until the final one
  p_stream_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);

  // R5: the final flag only rides on a valid code word
  p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R6: done follows the final code word and lasts one cycle
  p_done_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> done);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a too-short length raises err and opens no frame
  p_short_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start && frame_len < LEN_W'(MIN_LEN)) |=> (err && !in_ready));
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!out_valid && !in_ready));

  // R8: starts while busy never raise err
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && start) |=> !err);

endmodule

bind tailbite_conv_enc tbenc_checker #(
  .MIN_LEN (CODE_K - 1),
  .LEN_W   ($clog2(MAX_LEN + 1))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .frame_len (frame_len),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_last  (out_last),
  .done      (done),
  .err       (err),
  .st        (st)
);

// File: tb/tailbite_conv_enc_tb.sv
`timescale 1ns/1ps
module tailbite_conv_enc_tb;

  localparam int MAX_LEN = 384;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LEN_W-1:0] frame_len = '0;
  logic             in_valid = 1'b0;
  logic             in_bit = 1'b0;
  logic             in_ready;
  logic             out_valid;
  logic [2:0]       out_code;
  logic             out_last;
  logic             done;
  logic             err;

  always #10 clk = ~clk;

  tailbite_conv_enc #(.MAX_LEN(MAX_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
    .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .out_valid(out_valid), .out_code(out_code), .out_last(out_last),
    .done(done), .err(err)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int rx_n = 0;
  int first_cyc = 0;
  int last_cyc = 0;
  int done_n = 0;
  int done_cyc = 0;
  int err_n = 0;
  logic [2:0] rx [MAX_LEN];
  logic       rx_last [MAX_LEN];
  logic [2:0] exp_code [MAX_LEN];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (out_valid) begin
      if (rx_n < MAX_LEN) begin
        rx[rx_n]      = out_code;
        rx_last[rx_n] = out_last;
      end
      if (rx_n == 0) first_cyc = cyc;
      last_cyc = cyc;
      rx_n = rx_n + 1;
    end
    if (done) begin
      done_n   = done_n + 1;
      done_cyc = cyc;
    end
    if (err) err_n = err_n + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ref_encode(input logic [MAX_LEN-1:0] f, input int len);
    logic [5:0] s;
    logic [6:0] w;
    for (int j = 0; j < 6; j++) s[j] = f[len-1-j];
    for (int i = 0; i < len; i++) begin
      w = {f[i], s[0], s[1], s[2], s[3], s[4], s[5]};
      exp_code[i] = {^(w & 7'o165), ^(w & 7'o171), ^(w & 7'o133)};
      s = {s[4:0], f[i]};
    end
  endtask

  task automatic run_frame(input logic [MAX_LEN-1:0] f, input int len,
                           input int gap_pct, input bit poke_fill,
                           input bit poke_code);
    int idx;
    int guard;
    int done0;
    int err0;
    int bad;
    int first_bad;
    int lasts;
    bit acc;
    ref_encode(f, len);
    rx_n  = 0;
    done0 = done_n;
    err0  = err_n;
    @(negedge clk);
    start     = 1'b1;
    frame_len = LEN_W'(len);
    @(negedge clk);
    start = 1'b0;
    chk(in_ready == 1'b1, "R1", "in_ready after start", int'(in_ready), 1);
    idx   = 0;
    guard = 0;
    while (idx < len && guard < 20 * MAX_LEN) begin
      in_valid = (($urandom % 100) >= gap_pct);
      in_bit   = in_valid ? f[idx] : 1'($urandom);
      if (poke_fill && idx == len / 2) begin
        start     = 1'b1;
        frame_len = LEN_W'(7);
      end else begin
        start = 1'b0;
      end
      acc = in_valid && in_ready;
      @(negedge clk);
      if (acc) idx++;
      guard++;
    end
    in_valid = 1'b0;
    start    = 1'b0;
    chk(idx == len, "R1", "bits accepted", idx, len);
    if (poke_code) begin
      start     = 1'b1;
      frame_len = LEN_W'(3);
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done_n == done0 && guard < len + 50) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    chk(rx_n == len, "R2", "code word count", rx_n, len);
    chk(last_cyc - first_cyc == len - 1, "R2", "code word span", last_cyc - first_cyc, len - 1);
    bad = 0;
    first_bad = -1;
    lasts = 0;
    for (int i = 0; i < len && i < rx_n; i++) begin
      if (rx[i] !== exp_code[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
      if (rx_last[i]) lasts++;
    end
    chk(bad == 0, "R3/R4", "mismatched code words", bad, 0);
    if (first_bad >= 0)
      chk(1'b0, "R3", "first bad word value", int'(rx[first_bad]), int'(exp_code[first_bad]));
    chk(lasts == 1 && rx_n >= 1 && rx_last[rx_n-1] == 1'b1, "R5", "out_last count", lasts, 1);
    chk(done_n - done0 == 1, "R6", "done pulses", done_n - done0, 1);
    chk(done_cyc == last_cyc + 1, "R6", "done timing", done_cyc - last_cyc, 1);
    chk(err_n == err0, "R8", "err during frame", err_n - err0, 0);
    chk(in_ready == 1'b0, "R9", "in_ready after frame", int'(in_ready), 0);
  endtask

  task automatic bad_len(input int len);
    int err0;
    err0 = err_n;
    rx_n = 0;
    @(negedge clk);
    start     = 1'b1;
    frame_len = LEN_W'(len);
    @(negedge clk);
    start = 1'b0;
    chk(in_ready == 1'b0, "R7", "in_ready after bad start", int'(in_ready), 0);
    in_valid = 1'b1;
    in_bit   = 1'b1;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    chk(err_n - err0 == 1, "R7", "err pulses", err_n - err0, 1);
    chk(rx_n == 0, "R7", "code words after reject", rx_n, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [MAX_LEN-1:0] f;
    int len;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0 && out_valid == 1'b0 && out_last == 1'b0, "R10",
        "idle outputs after reset", int'({in_ready, out_valid, out_last}), 0);
    chk(done == 1'b0 && err == 1'b0, "R10", "done/err after reset", int'({done, err}), 0);

    // R4 directed: all-ones six-bit frame codes to 3'b111 everywhere
    f = '1;
    run_frame(f, 6, 0, 1'b0, 1'b0);
    chk(rx[0] == 3'b111 && rx[5] == 3'b111, "R4", "all-ones preload words",
        int'({rx[0], rx[5]}), 6'o77);

    // boundary: full length, random content, with gaps
    for (int i = 0; i < MAX_LEN; i++) f[i] = 1'($urandom);
    run_frame(f, MAX_LEN, 30, 1'b0, 1'b0);

    // R8: starts while collecting and while coding
    for (int i = 0; i < MAX_LEN; i++) f[i] = 1'($urandom);
    run_frame(f, 20, 20, 1'b1, 1'b1);

    // R7: rejected lengths, then a good frame still works
    bad_len(0);
    bad_len(5);
    bad_len(MAX_LEN + 1);

    for (int t = 0; t < 10; t++) begin
      for (int i = 0; i < MAX_LEN; i++) f[i] = 1'($urandom);
      len = 6 + int'($urandom % 90);
      run_frame(f, len, int'($urandom % 60), 1'($urandom), 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule